// File: doc/BRIEF.md
# Region-Weighted Random Sensing Matrix Generator

This block fills a binary sensing matrix for a compressive-sensing front end, one full row on each clock. Every column has a private random source sitting at its head that only ever feeds that column. The source is a 16-bit pseudo-random shift register whose state is compared against a threshold. The comparison result is caught in a flip-flop, so every stored entry is a clean 0 or 1. A larger threshold means a larger chance of a 1.

Software sets two thresholds and an inclusive column window while the block is idle. Columns inside the window take the "dense" threshold and all others take the "sparse" threshold. This lets a region of interest in the signal collect more nonzero entries. The thresholds can be retuned between generations as sparsity or noise changes. A start pulse launches a generation. The block then drives a row address and a row word into the matrix memory on consecutive cycles and flags completion with a one-cycle pulse.

Top module: `sparse_matrix_gen`

## Requirements
- R1: After reset, `wr_en`, `done` and `busy` are 0, the configuration registers are all 0, and column c's generator holds the seed ((c+1)·0x9E37) mod 2^16.
- R2: Each column generator is a right-shifting 16-bit register s whose next value is {s[0]^s[2]^s[3]^s[5], s[15:1]}. For an emitted row, `wr_data[c]` is 1 exactly when column c's current value is below that column's threshold, read as unsigned numbers. The generator then takes one step.
- R3: Column c uses the dense threshold when lo ≤ c ≤ hi, with both ends inclusive, and the sparse threshold otherwise. When lo > hi, no column is in the window.
- R4: Configuration writes select their target with `cfg_sel`: 0 sets the sparse threshold, 1 the dense threshold, 2 lo and 3 hi. lo and hi take the low 6 bits of `cfg_wdata`. A write made while `busy` is 1 is ignored.
- R5: A start pulse accepted at an edge yields rows 0 to NROWS-1 on the NROWS consecutive cycles that follow, with `wr_en` high, in ascending address order.
- R6: `done` is high for exactly one cycle, the cycle right after the cycle that carries the last row.
- R7: `busy` is 1 from the cycle after an accepted start through the last row cycle. A start seen while `busy` is 1 is ignored and produces no extra rows.
- R8: A threshold of 0 gives all-zero entries in its columns. A threshold of 0xFFFF gives 1 in every row except where the generator value is 0xFFFF.
- R9: Generators step only when a row is emitted. They carry their state from one generation to the next, and only reset returns them to their seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 16 | Configuration write value |
| start | input | 1 | Generation request pulse |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Matrix memory row write enable |
| wr_addr | output | 5 | Row address |
| wr_data | output | 50 | Row word; bit c is column c |

## Verification
The bench builds the block with its defaults of 25 rows and 50 columns, so a full generation is short and the window limits can sit on column 0 and column 49. It mirrors all fifty column generators across several generations without a reset between them. It also tries windows that are empty, that cover everything, and that split the row in half. It uses thresholds of 0 and 0xFFFF and mid-range values, and it issues start pulses and configuration writes during a run. A reset in the middle of the sequence checks that the seeds reload.

// File: rtl/smg_pkg.sv
package smg_pkg;
  localparam int LFSR_W = 16;

  typedef enum logic [1:0] {
    CFG_SPARSE = 2'd0,
    CFG_DENSE  = 2'd1,
    CFG_LO     = 2'd2,
    CFG_HI     = 2'd3
  } cfg_sel_e;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[LFSR_W-1:1]};
  endfunction

  function automatic logic [LFSR_W-1:0] col_seed(input int c);
    return LFSR_W'((c + 1) * 32'h0000_9E37);
  endfunction
endpackage

// File: rtl/smg_cfg_regs.sv
module smg_cfg_regs
  import smg_pkg::*;
#(
  parameter int NCOLS = 50,
  localparam int COL_W = $clog2(NCOLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [LFSR_W-1:0] cfg_wdata,
  output logic [LFSR_W-1:0] thr_sparse,
  output logic [LFSR_W-1:0] thr_dense,
  output logic [COL_W-1:0]  win_lo,
  output logic [COL_W-1:0]  win_hi
);
  logic              wr_ok;
  logic [LFSR_W-1:0] sparse_d, dense_d;
  logic [COL_W-1:0]  lo_d, hi_d;

  assign wr_ok = cfg_we && !lock;

  always_comb begin
    sparse_d = thr_sparse;
    dense_d  = thr_dense;
    lo_d     = win_lo;
    hi_d     = win_hi;
    if (wr_ok) begin
      unique case (cfg_sel_e'(cfg_sel))
        CFG_SPARSE: sparse_d = cfg_wdata;
        CFG_DENSE:  dense_d  = cfg_wdata;
        CFG_LO:     lo_d     = cfg_wdata[COL_W-1:0];
        CFG_HI:     hi_d     = cfg_wdata[COL_W-1:0];
        default:    sparse_d = thr_sparse;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_sparse <= '0;
      thr_dense  <= '0;
      win_lo     <= '0;
      win_hi     <= '0;
    end else if (wr_ok) begin
      thr_sparse <= sparse_d;
      thr_dense  <= dense_d;
      win_lo     <= lo_d;
      win_hi     <= hi_d;
    end
  end
endmodule

// File: rtl/smg_col_src.sv
module smg_col_src
  import smg_pkg::*;
#(
  parameter int COL_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [LFSR_W-1:0] thr,
  output logic              bit_q
);
  localparam logic [LFSR_W-1:0] SEED = col_seed(COL_IDX);

  logic [LFSR_W-1:0] state_q, state_d;
  logic              bit_d;

  always_comb begin
    state_d = lfsr_step(state_q);
    bit_d   = (state_q < thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
      bit_q   <= 1'b0;
    end else if (adv) begin
      state_q <= state_d;
      bit_q   <= bit_d;
    end
  end
endmodule

// File: rtl/smg_row_ctrl.sv
module smg_row_ctrl #(
  parameter int NROWS = 25,
  localparam int ROW_W = $clog2(NROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             adv,
  output logic             busy,
  output logic             wr_en,
  output logic [ROW_W-1:0] wr_addr,
  output logic             done
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(NROWS - 1);

  logic             run_q, run_d;
  logic [ROW_W-1:0] cnt_q, cnt_d;
  logic             wen_d, done_d;
  logic [ROW_W-1:0] addr_d;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    wen_d  = 1'b0;
    addr_d = wr_addr;
    done_d = wr_en && (wr_addr == LAST);
    if (run_q) begin
      wen_d  = 1'b1;
      addr_d = cnt_q;
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == LAST) run_d = 1'b0;
    end else if (start && !wr_en) begin
      run_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      done    <= 1'b0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      wr_en   <= wen_d;
      wr_addr <= addr_d;
      done    <= done_d;
    end
  end

  assign adv  = run_q;
  assign busy = run_q | wr_en;
endmodule

// File: rtl/sparse_matrix_gen.sv
module sparse_matrix_gen
  import smg_pkg::*;
#(
  parameter int NROWS = 25,
  parameter int NCOLS = 50,
  localparam int ROW_W = $clog2(NROWS),
  localparam int COL_W = $clog2(NCOLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [LFSR_W-1:0] cfg_wdata,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_addr,
  output logic [NCOLS-1:0]  wr_data
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              adv;
  logic [LFSR_W-1:0] thr_sparse, thr_dense;
  logic [COL_W-1:0]  win_lo, win_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  smg_cfg_regs #(.NCOLS(NCOLS)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lock       (busy),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .thr_sparse (thr_sparse),
    .thr_dense  (thr_dense),
    .win_lo     (win_lo),
    .win_hi     (win_hi)
  );

  smg_row_ctrl #(.NROWS(NROWS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .adv     (adv),
    .busy    (busy),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .done    (done)
  );

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    localparam logic [COL_W-1:0] CIDX = COL_W'(c);
    logic              in_win;
    logic [LFSR_W-1:0] thr_c;
    assign in_win = (CIDX >= win_lo) && (CIDX <= win_hi);
    assign thr_c  = in_win ? thr_dense : thr_sparse;

    smg_col_src #(.COL_IDX(c)) u_src (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .adv   (adv),
      .thr   (thr_c),
      .bit_q (wr_data[c])
    );
  end
endmodule

// File: rtl/smg_checker.sv
module smg_checker #(
  parameter int NROWS = 25,
  localparam int ROW_W = $clog2(NROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             wr_en,
  input logic [ROW_W-1:0] wr_addr,
  input logic [15:0]      thr_sparse,
  input logic [15:0]      thr_dense
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(NROWS - 1);

  assert_first_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> wr_addr == '0);

  assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != LAST) |=> (wr_en && wr_addr == ROW_W'($past(wr_addr) + 1'b1)));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LAST) |=> (done && !wr_en));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(thr_sparse) && $stable(thr_dense)));

  assert_busy_covers_rows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
endmodule

bind sparse_matrix_gen smg_checker #(.NROWS(NROWS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .busy       (busy),
  .done       (done),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .thr_sparse (thr_sparse),
  .thr_dense  (thr_dense)
);

// File: tb/sparse_matrix_gen_tb.sv
`timescale 1ns/1ps
module sparse_matrix_gen_tb;
  localparam int NROWS = 25;
  localparam int NCOLS = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        start = 1'b0;
  logic        busy, done, wr_en;
  logic [4:0]  wr_addr;
  logic [NCOLS-1:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [15:0] m_lfsr [NCOLS];
  logic [15:0] m_sparse, m_dense;
  int          m_lo, m_hi;
  logic [4:0]       q_addr [$];
  logic [NCOLS-1:0] q_data [$];
  bit prev_last = 0;

  always #2.5 clk = ~clk;

  sparse_matrix_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCOLS; c++) m_lfsr[c] = 16'((c + 1) * 32'h9E37);
    m_sparse = 0; m_dense = 0; m_lo = 0; m_hi = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    prev_last = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    check(!busy && !done && !wr_en, "R1", {busy, done, wr_en}, 0);
  endtask

  task automatic cfg(input int sel, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: m_sparse = v;
      1: m_dense = v;
      2: m_lo = int'(v[5:0]);
      default: m_hi = int'(v[5:0]);
    endcase
  endtask

  task automatic push_rows();
    for (int r = 0; r < NROWS; r++) begin
      logic [NCOLS-1:0] row;
      for (int c = 0; c < NCOLS; c++) begin
        logic [15:0] t;
        t = (c >= m_lo && c <= m_hi) ? m_dense : m_sparse;   // R3 window
        row[c] = (m_lfsr[c] < t);                            // R2 compare
        m_lfsr[c] = step(m_lfsr[c]);                         // R9 step per row
      end
      q_addr.push_back(5'(r));
      q_data.push_back(row);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    check(done == 1'b1, "R6", done, 1);
  endtask

  task automatic launch();
    push_rows();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: busy after accepted start
    check(busy == 1'b1, "R7", busy, 1);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wr_en) begin
        if (q_addr.size() == 0) begin
          check(0, "R7", {wr_addr, wr_data}, 0);
        end else begin
          logic [4:0] ea;
          logic [NCOLS-1:0] ed;
          ea = q_addr.pop_front();
          ed = q_data.pop_front();
          check(wr_addr == ea, "R5", wr_addr, ea);
          check(wr_data == ed, "R2", wr_data, ed);
        end
      end
      if (done || prev_last) check(done == prev_last, "R6", done, prev_last);
      prev_last = wr_en && (wr_addr == 5'(NROWS - 1));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R2 R3 R5: mid thresholds, interior window
    cfg(0, 16'h4000); cfg(1, 16'hC000); cfg(2, 16'd10); cfg(3, 16'd19);
    launch(); wait_done();
    // R9: continue without reset
    launch(); wait_done();

    // R3: empty window lo > hi
    cfg(0, 16'h8000); cfg(1, 16'hFFFF); cfg(2, 16'd30); cfg(3, 16'd5);
    launch(); wait_done();

    // R3 R8: half window at column 0 edge, extremes
    cfg(0, 16'h0000); cfg(1, 16'hFFFF); cfg(2, 16'd0); cfg(3, 16'd24);
    launch(); wait_done();
    // R3 R8: window ending on last column
    cfg(2, 16'd25); cfg(3, 16'd49);
    launch(); wait_done();

    // R4 R7: start and config writes during a run are ignored
    cfg(0, 16'h3000); cfg(1, 16'h9000); cfg(2, 16'd7); cfg(3, 16'd40);
    launch();
    repeat (3) @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h1234; start = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0;
    wait_done();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!wr_en && !busy, "R7", {wr_en, busy}, 0);
    end
    // R4: the old sparse threshold must still apply
    launch(); wait_done();

    // R1 R9: reset reloads seeds; reset config gives column 0 threshold 0
    do_reset();
    launch(); wait_done();
    cfg(0, 16'h5555); cfg(1, 16'hE000); cfg(2, 16'd49); cfg(3, 16'd49);
    launch(); wait_done();

    repeat (3) @(negedge clk);
    check(q_addr.size() == 0, "R5", q_addr.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule